// File: doc/BRIEF.md
# Two-Button Volume Knob Controller

This block turns a pair of active-low push buttons into a 7-bit volume value. A new press on either button starts a settling wait whose length comes from a 3-bit rate setting; the button levels seen when that wait ends decide what happens. Up steps the volume by one code, down steps it back by one, and both together mute it. While the volume is muted, any press restores the value held before the mute. The volume saturates at both ends, and every action raises a one-cycle event strobe that a response path can use to tell software that the knob moved.

With the continuous option set, a held button keeps stepping at the same interval until it is released. Software may overwrite the volume at any time. In direct mode the knob value is combined with a DAC amplifier code into an effective gain code, clamped at the bottom of the range. In indirect mode the DAC code passes through unchanged.

Top module: `volknob_ctrl`

## Requirements
- R1: After reset the volume is 0x7F, the mute flag is 0 and the event strobe is 0.
- R2: A new press on either button (a button whose synchronised level goes from released to pressed) starts a wait of P = (2·CLK_HZ)/(5·(rate+1)) clock cycles, using integer division. The action is taken on the clock edge P cycles after the first edge that sees the press, so the event rises P+3 clock edges after the button input first reads low at a clock edge. If both buttons read released when the wait ends, nothing happens and no event is raised.
- R3: An action with only up held increments the volume by one. An action with only down held decrements it by one. Each action drives the event strobe high for exactly one cycle, in the cycle in which the new volume first appears.
- R4: An action with both buttons held, while the volume is not muted, stores the current volume, sets the volume to 0 and sets the mute flag to 1. While muted, the volume reads 0.
- R5: Any action while muted restores the stored volume and clears the mute flag, without stepping the volume.
- R6: The volume saturates at 0x7F going up and at 0x00 going down. An action at a limit still raises the event.
- R7: With the continuous input at 1, a held button repeats its action every P cycles after the first action, until both buttons read released. With the continuous input at 0, a press gives one action however long it is held.
- R8: Further presses during a settling wait neither restart nor extend that wait. Both buttons are judged when the original wait ends.
- R9: A software write loads the volume and clears the mute flag on the next edge. It takes priority over a button action on the same edge, although that action still raises the event.
- R10: With the direct input at 1, the gain output is max(0, volume + dac_code − 0x7F). With the direct input at 0, it equals dac_code, whatever the volume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ hertz |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_up_n | input | 1 | Up button, low when pressed, asynchronous |
| btn_dn_n | input | 1 | Down button, low when pressed, asynchronous |
| cfg_rate | input | 3 | Rate code n, giving (n+1)·2.5 Hz for settling and repeat |
| cfg_cont | input | 1 | 1 = repeat while held |
| cfg_direct | input | 1 | 1 = combine knob and DAC codes into the gain output |
| sw_we | input | 1 | Software write strobe for the volume |
| sw_vol | input | VW | Value loaded by a software write |
| dac_code | input | VW | DAC amplifier gain code (0x7F = 0 dB) |
| knob_vol | output | VW | Current volume code |
| knob_muted | output | 1 | Mute flag |
| knob_evt | output | 1 | One-cycle strobe for each button action |
| dac_gain | output | VW | Effective DAC gain code |

## Verification
The bench checks the exact edge on which the settling wait ends: a counter that is off by one moves the event by a cycle, and a design that restarts the wait on a second press fires late when the other button joins mid-wait. It checks the press that is released before the wait ends (a design that acts on the edge alone steps anyway), saturation at both limits (a design that wraps goes from 0x7F to 0 or from 0 to 0x7F), and unmuting (a design that steps instead of restoring lands on the wrong value). It also checks a software write on the same edge as a button action, and the floor of the direct-mode sum, where an unsaturated subtraction wraps to a large code.

// File: rtl/volk_pkg.sv
// Shared types and helpers for the volume knob controller.
// Assumes rate codes 0..7 map to (code+1)*2.5 Hz.
package volk_pkg;

    typedef enum logic [1:0] {
        VK_IDLE   = 2'd0,
        VK_SETTLE = 2'd1,
        VK_REPEAT = 2'd2
    } vk_state_e;

    // Clock cycles in one period of (code+1)*2.5 Hz.
    function automatic int vk_period(input int clk_hz, input int code);
        return (2 * clk_hz) / (5 * (code + 1));
    endfunction

endpackage

// File: rtl/volk_sync.sv
// Two-stage synchroniser plus new-press detect for W active-low buttons.
// Assumes the button inputs are asynchronous and not yet debounced.
module volk_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] btn_n,
    output logic [W-1:0] lvl,
    output logic [W-1:0] press
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    // Shift the raw levels through the sync chain; reset reads released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
            s3_q <= '1;
        end else begin
            s1_q <= btn_n;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Per-button pressed level and released-to-pressed detect.
    for (genvar g = 0; g < W; g++) begin : g_btn
        assign lvl[g]   = ~s2_q[g];
        assign press[g] = ~s2_q[g] & s3_q[g];
    end
endmodule

// File: rtl/volk_timer.sv
// Down-counter for the settling and repeat interval chosen by the rate code.
// Assumes that start reloads it and done reads high once the count reaches zero.
module volk_timer #(
    parameter int CLK_HZ = 4000,
    parameter int CW     = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] rate,
    output logic       done
);
    import volk_pkg::*;

    localparam int NRATE = 8;

    logic [CW-1:0] per_tab [NRATE];
    logic [CW-1:0] cnt_q;

    // Reload values, one for each rate code, computed at elaboration.
    for (genvar g = 0; g < NRATE; g++) begin : g_per
        assign per_tab[g] = CW'(vk_period(CLK_HZ, g) - 1);
    end

    // Load on start, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start)       cnt_q <= per_tab[rate];
        else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R2: a freshly loaded wait never ends on the very next edge.
    p_no_early_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);
endmodule

// File: rtl/volk_core.sv
// Press state machine and volume register with mute, saturation and software write.
// Assumes the levels and the press flag are already synchronised.
module volk_core #(
    parameter int VW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_up,
    input  logic          lvl_dn,
    input  logic          press_any,
    input  logic          tmr_done,
    input  logic          cfg_cont,
    input  logic          sw_we,
    input  logic [VW-1:0] sw_vol,
    output logic          tmr_start,
    output logic [VW-1:0] vol,
    output logic          muted,
    output logic          evt
);
    import volk_pkg::*;

    localparam logic [VW-1:0] VMAX = '1;

    vk_state_e     state_q, state_d;
    logic          act;
    logic [VW-1:0] vol_q, vol_d, save_q, save_d;
    logic          mut_q, mut_d, evt_q;
    logic          any_held;

    assign any_held = lvl_up | lvl_dn;

    // Next state, timer start and action strobe.
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        act       = 1'b0;
        case (state_q)
            VK_IDLE: begin
                if (press_any) begin
                    state_d   = VK_SETTLE;
                    tmr_start = 1'b1;
                end
            end
            VK_SETTLE: begin
                if (tmr_done) begin
                    act = any_held;
                    if (cfg_cont && any_held) begin
                        state_d   = VK_REPEAT;
                        tmr_start = 1'b1;
                    end else begin
                        state_d = VK_IDLE;
                    end
                end
            end
            VK_REPEAT: begin
                if (!any_held) begin
                    state_d = VK_IDLE;
                end else if (tmr_done) begin
                    act       = 1'b1;
                    tmr_start = 1'b1;
                end
            end
            default: state_d = VK_IDLE;
        endcase
    end

    // Next volume, saved value and mute flag.
    always_comb begin
        vol_d  = vol_q;
        save_d = save_q;
        mut_d  = mut_q;
        if (act) begin
            if (mut_q) begin
                vol_d = save_q;
                mut_d = 1'b0;
            end else if (lvl_up && lvl_dn) begin
                save_d = vol_q;
                vol_d  = '0;
                mut_d  = 1'b1;
            end else if (lvl_up) begin
                if (vol_q != VMAX) vol_d = vol_q + 1'b1;
            end else begin
                if (vol_q != '0) vol_d = vol_q - 1'b1;
            end
        end
        if (sw_we) begin
            vol_d = sw_vol;
            mut_d = 1'b0;
        end
    end

    // Register state, volume and the event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VK_IDLE;
            vol_q   <= VMAX;
            save_q  <= VMAX;
            mut_q   <= 1'b0;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            vol_q   <= vol_d;
            save_q  <= save_d;
            mut_q   <= mut_d;
            evt_q   <= act;
        end
    end

    assign vol   = vol_q;
    assign muted = mut_q;
    assign evt   = evt_q;

    p_evt_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(state_q) != VK_IDLE);

    p_mute_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mut_q |-> vol_q == '0);

    p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !mut_q && lvl_up && !lvl_dn && !sw_we && vol_q == VMAX) |=> vol_q == VMAX);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VK_IDLE && !sw_we) |=> ($stable(vol_q) && $stable(mut_q)));
endmodule

// File: rtl/volk_gain.sv
// Effective DAC gain: knob plus DAC code less full scale, floored at zero, in direct mode.
// Assumes code all-ones means 0 dB for both operands.
module volk_gain #(
    parameter int VW = 7
) (
    input  logic          direct,
    input  logic [VW-1:0] knob,
    input  logic [VW-1:0] dac,
    output logic [VW-1:0] gain
);
    localparam logic [VW:0] FULL = {1'b0, {VW{1'b1}}};

    logic [VW:0] sum;
    logic [VW:0] diff;

    // Add the two codes and floor the attenuation sum at code zero.
    always_comb begin
        sum  = {1'b0, knob} + {1'b0, dac};
        diff = (sum > FULL) ? (sum - FULL) : '0;
        gain = direct ? diff[VW-1:0] : dac;
    end

    // R10: combining never raises the gain above the DAC code.
    always_comb begin
        p_gain_floor_r10: assert (!direct || gain <= dac);
    end
endmodule

// File: rtl/volknob_ctrl.sv
// Two-button volume knob controller: synchroniser, interval timer, press FSM, gain combiner.
// Assumes CLK_HZ is large enough that every rate period is at least a few cycles.
module volknob_ctrl #(
    parameter int CLK_HZ = 4000,
    parameter int VW     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          btn_up_n,
    input  logic          btn_dn_n,
    input  logic [2:0]    cfg_rate,
    input  logic          cfg_cont,
    input  logic          cfg_direct,
    input  logic          sw_we,
    input  logic [VW-1:0] sw_vol,
    input  logic [VW-1:0] dac_code,
    output logic [VW-1:0] knob_vol,
    output logic          knob_muted,
    output logic          knob_evt,
    output logic [VW-1:0] dac_gain
);
    localparam int CW = $clog2(2 * CLK_HZ / 5 + 1);

    logic [1:0] lvl, press;
    logic       tmr_start, tmr_done;

    volk_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_n ({btn_up_n, btn_dn_n}),
        .lvl   (lvl),
        .press (press)
    );

    volk_timer #(.CLK_HZ(CLK_HZ), .CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .rate  (cfg_rate),
        .done  (tmr_done)
    );

    volk_core #(.VW(VW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_up    (lvl[1]),
        .lvl_dn    (lvl[0]),
        .press_any (|press),
        .tmr_done  (tmr_done),
        .cfg_cont  (cfg_cont),
        .sw_we     (sw_we),
        .sw_vol    (sw_vol),
        .tmr_start (tmr_start),
        .vol       (knob_vol),
        .muted     (knob_muted),
        .evt       (knob_evt)
    );

    volk_gain #(.VW(VW)) u_gain (
        .direct (cfg_direct),
        .knob   (knob_vol),
        .dac    (dac_code),
        .gain   (dac_gain)
    );
endmodule

// File: tb/volknob_ctrl_tb.sv
module volknob_ctrl_tb;
    localparam int CLK_HZ  = 4000;
    localparam int CLK_PER = 10;
    localparam int VW      = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_up_n = 1'b1, btn_dn_n = 1'b1;
    logic [2:0] cfg_rate = 3'd7;
    logic cfg_cont = 1'b0, cfg_direct = 1'b0, sw_we = 1'b0;
    logic [VW-1:0] sw_vol = '0, dac_code = 7'h7F;
    logic [VW-1:0] knob_vol, dac_gain;
    logic knob_muted, knob_evt;

    int checks = 0, fails = 0, ev_cnt = 0, ticks = 0;

    // Reference model state.
    logic [3:0] hu = '1, hd = '1;
    int m_vol = 127, m_save = 127, m_mut = 0, m_evt = 0, m_st = 0, m_cnt = 0;

    always #(CLK_PER/2) clk = ~clk;

    volknob_ctrl #(.CLK_HZ(CLK_HZ), .VW(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_up_n(btn_up_n), .btn_dn_n(btn_dn_n),
        .cfg_rate(cfg_rate), .cfg_cont(cfg_cont), .cfg_direct(cfg_direct),
        .sw_we(sw_we), .sw_vol(sw_vol), .dac_code(dac_code),
        .knob_vol(knob_vol), .knob_muted(knob_muted), .knob_evt(knob_evt),
        .dac_gain(dac_gain)
    );

    function automatic int per(input int code);
        return (2 * CLK_HZ) / (5 * (code + 1));
    endfunction

    // Behavioural model: the decision uses inputs seen two edges back.
    always @(posedge clk) begin
        bit lu, ld, pu, pd, act;
        if (!rst_n) begin
            hu = '1; hd = '1; m_vol = 127; m_save = 127; m_mut = 0;
            m_evt = 0; m_st = 0; m_cnt = 0;
        end else begin
            hu = {hu[2:0], btn_up_n};
            hd = {hd[2:0], btn_dn_n};
            lu = !hu[2]; ld = !hd[2]; pu = !hu[3]; pd = !hd[3];
            act = 0;
            if (m_st == 0) begin
                if ((lu && !pu) || (ld && !pd)) begin m_st = 1; m_cnt = per(cfg_rate) - 1; end
            end else if (m_st == 1) begin
                if (m_cnt == 0) begin
                    act = lu || ld;
                    if (cfg_cont && (lu || ld)) begin m_st = 2; m_cnt = per(cfg_rate) - 1; end
                    else m_st = 0;
                end else m_cnt--;
            end else begin
                if (!lu && !ld) m_st = 0;
                else if (m_cnt == 0) begin act = 1; m_cnt = per(cfg_rate) - 1; end
                else m_cnt--;
            end
            m_evt = act;
            if (act) begin
                if (m_mut != 0) begin m_vol = m_save; m_mut = 0; end
                else if (lu && ld) begin m_save = m_vol; m_vol = 0; m_mut = 1; end
                else if (lu) m_vol = (m_vol < 127) ? m_vol + 1 : 127;
                else m_vol = (m_vol > 0) ? m_vol - 1 : 0;
            end
            if (sw_we) begin m_vol = sw_vol; m_mut = 0; end
        end
    end

    // Per-cycle comparison against the model (all of R1 to R10).
    always @(negedge clk) begin
        int eg;
        ticks++;
        if (rst_n) begin
            eg = cfg_direct ? ((m_vol + dac_code > 127) ? m_vol + dac_code - 127 : 0) : dac_code;
            checks++;
            if (knob_vol != m_vol || knob_muted != m_mut || knob_evt != m_evt || dac_gain != eg) begin
                fails++;
                $display("FAIL model R3/R10 t=%0d actual vol=%0d mut=%0d evt=%0d gain=%0d expected vol=%0d mut=%0d evt=%0d gain=%0d",
                         ticks, knob_vol, knob_muted, knob_evt, dac_gain, m_vol, m_mut, m_evt, eg);
            end
            if (knob_evt) ev_cnt++;
        end
        if (ticks > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic swrite(input int v);
        sw_we = 1'b1; sw_vol = VW'(v);
        step(1);
        sw_we = 1'b0;
    endtask

    initial begin
        int p, e0;
        p = per(7);
        step(5);
        rst_n = 1'b1;
        step(2);
        chk("R1 reset vol", knob_vol, 127);
        chk("R1 reset mute", knob_muted, 0);
        chk("R1 reset evt", knob_evt, 0);

        // R2 timing and R6 top saturation.
        btn_up_n = 1'b0; e0 = ev_cnt;
        step(p + 2);
        chk("R2 no event before wait ends", ev_cnt - e0, 0);
        step(1);
        chk("R2 event at end of wait", knob_evt, 1);
        chk("R6 saturate at 0x7F", knob_vol, 127);
        btn_up_n = 1'b1; step(10);

        // R3 down step, one-cycle strobe; R7 hold without continuous.
        btn_dn_n = 1'b0;
        step(p + 3);
        chk("R3 down decrements", knob_vol, 126);
        step(1);
        chk("R3 strobe lasts one cycle", knob_evt, 0);
        step(3 * p);
        chk("R7 one action per press", knob_vol, 126);
        btn_dn_n = 1'b1; step(5);

        btn_up_n = 1'b0;
        step(p + 3);
        chk("R3 up increments", knob_vol, 127);
        btn_up_n = 1'b1; step(5);

        // R2 press released before the wait ends.
        btn_dn_n = 1'b0; step(20); btn_dn_n = 1'b1; e0 = ev_cnt;
        step(p + 10);
        chk("R2 released press no action", knob_vol, 127);
        chk("R2 released press no event", ev_cnt - e0, 0);

        // R8 second press does not restart; R4 chord mutes.
        btn_dn_n = 1'b0; step(p / 2); btn_up_n = 1'b0;
        step(p - p / 2 + 3);
        chk("R8 original wait kept", knob_evt, 1);
        chk("R4 chord mutes", knob_muted, 1);
        chk("R4 muted volume zero", knob_vol, 0);
        btn_up_n = 1'b1; btn_dn_n = 1'b1; step(5);

        // R5 unmute restores.
        btn_up_n = 1'b0;
        step(p + 3);
        chk("R5 unmute clears flag", knob_muted, 0);
        chk("R5 unmute restores value", knob_vol, 127);
        btn_up_n = 1'b1; step(5);

        // R7 continuous repeat.
        cfg_cont = 1'b1; btn_dn_n = 1'b0;
        step(p + 3);
        chk("R7 first action", knob_vol, 126);
        step(3 * p);
        chk("R7 repeats every period", knob_vol, 123);
        step(p / 2); btn_dn_n = 1'b1;
        step(2 * p);
        chk("R7 stops on release", knob_vol, 123);
        cfg_cont = 1'b0;

        // R9 write, R6 bottom saturation.
        swrite(1);
        chk("R9 write loads", knob_vol, 1);
        btn_dn_n = 1'b0; step(p + 3); btn_dn_n = 1'b1; step(5);
        chk("R6 reaches zero", knob_vol, 0);
        btn_dn_n = 1'b0; step(p + 3);
        chk("R6 event at floor", knob_evt, 1);
        chk("R6 saturate at 0", knob_vol, 0);
        btn_dn_n = 1'b1; step(5);

        // R9 write clears mute.
        swrite(50);
        btn_up_n = 1'b0; btn_dn_n = 1'b0; step(p + 3);
        chk("R4 chord from 50", knob_muted, 1);
        btn_up_n = 1'b1; btn_dn_n = 1'b1; step(5);
        swrite(63);
        chk("R9 write clears mute", knob_muted, 0);
        chk("R9 write value while muted", knob_vol, 63);

        // R9 write and action on the same edge.
        btn_up_n = 1'b0; step(p + 2);
        sw_we = 1'b1; sw_vol = 7'h10; step(1); sw_we = 1'b0;
        chk("R9 write wins", knob_vol, 16);
        chk("R9 event still raised", knob_evt, 1);
        btn_up_n = 1'b1; step(5);

        // R10 gain combining.
        swrite(63);
        cfg_direct = 1'b1; dac_code = 7'h7F; step(1);
        chk("R10 knob 0x3F dac 0x7F", dac_gain, 63);
        dac_code = 7'h1F; step(1);
        chk("R10 floor clamp", dac_gain, 0);
        dac_code = 7'h50; step(1);
        chk("R10 partial sum", dac_gain, 16);
        cfg_direct = 1'b0; step(1);
        chk("R10 indirect passes dac", dac_gain, 8'h50);
        btn_up_n = 1'b0; step(p + 3); btn_up_n = 1'b1; step(2);
        chk("R10 knob moved", knob_vol, 64);
        chk("R10 indirect ignores knob", dac_gain, 8'h50);
        step(3);

        // R2 at another rate.
        cfg_rate = 3'd3; p = per(3);
        btn_dn_n = 1'b0; step(p + 2);
        chk("R2 rate 3 before end", knob_vol, 64);
        step(1);
        chk("R2 rate 3 at end", knob_vol, 63);
        btn_dn_n = 1'b1; step(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule